// File: doc/BRIEF.md
# Decimal Adder/Subtractor for Packed BCD

This block is a purely combinational arithmetic unit for packed 8421 BCD numbers of `DIGITS` decimal places. Each place takes one 4-bit code from each operand. It adds the two codes in binary together with the decimal carry from the place below. When the raw sum is not a legal decimal digit, or when it carries out of four bits, the place adds six. That correction also sends a decimal carry to the next place up.

For subtraction, the mode input turns every subtrahend digit into nine minus that digit before the addition. The caller then holds the carry-in at 1, and the sum becomes the ten's complement difference. The end carry tells the sign: a 1 means the difference is non-negative and already correct, and a 0 means the result is the ten's complement of a negative difference. The unit is meant to sit in a decimal datapath with registers on either side. Its delay is one ripple through all the places.

Top module: `bcd_addsub`

## Requirements
- R1: With `sub_mode`=0, `result` equals (A+B+`cin`) mod 10^DIGITS. Decimal place i of every operand and of `result` sits in bits [4i+3:4i], and place 0 is the least significant.
- R2: A place whose binary sum (digits plus incoming carry) is 9 or less outputs that sum unchanged and passes no carry upward.
- R3: A place whose binary sum lies between 10 and 19 outputs the sum minus 10 and passes a carry of 1 to the next place.
- R4: The largest place sum, 9+9+1, yields digit 9 with a carry of 1. With all digits at 9 and `cin`=1, the result is all nines and `cout`=1.
- R5: Carries ripple from the least significant place upward. All nines plus 1 gives all zeros with `cout`=1.
- R6: With `sub_mode`=1, each B digit d is used as 9−d. With `cin`=1, `result` equals (A−B) mod 10^DIGITS.
- R7: In subtract mode with `cin`=1 and A ≥ B, `cout`=1 and `result` = A−B.
- R8: In subtract mode with `cin`=1 and A < B, `cout`=0 and `result` = 10^DIGITS − (B−A).
- R9: `cout` is 1 exactly when the decimal total (A plus the effective B plus `cin`) reaches 10^DIGITS.
- R10: In subtract mode with `cin`=0, `result` and `cout` are the sum of A and the nine's complement of B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | 4*DIGITS | Operand A, packed BCD |
| opb | input | 4*DIGITS | Operand B, packed BCD (the subtrahend in subtract mode) |
| sub_mode | input | 1 | 0 adds, 1 replaces each B digit by its nine's complement |
| cin | input | 1 | Carry into place 0 (set to 1 for a true difference) |
| result | output | 4*DIGITS | Packed BCD result |
| cout | output | 1 | Decimal carry out of the top place |

## Verification
The block holds no state, so a fault in the correction condition, the complement generator or the carry chain shows up in the outputs as soon as the inputs settle. A missed correction leaves a code of 10 to 15 in some place, or drops a carry, and the whole-number comparison catches it. Subtraction faults show as a wrong sign in `cout` or a wrong complement value. Every digit pair in both modes and with both carry-in values is applied at every place at once, and many random multi-digit operands follow, so faults that only show when carries chain across places are also exposed.

// File: rtl/bcd_addsub.sv
module bcd_addsub #(
  parameter int DIGITS = 3,
  localparam int W = 4 * DIGITS
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         sub_mode,
  input  logic         cin,
  output logic [W-1:0] result,
  output logic         cout
);

  logic [DIGITS:0] dcarry;

  assign dcarry[0] = cin;
  assign cout      = dcarry[DIGITS];

  for (genvar g = 0; g < DIGITS; g++) begin : g_place
    logic [3:0] a_d, b_d, b_eff, out_d;
    logic [4:0] raw;
    logic       fix;

    assign a_d   = opa[4*g +: 4];
    assign b_d   = opb[4*g +: 4];
    assign b_eff = sub_mode ? (4'd9 - b_d) : b_d;
    assign raw   = {1'b0, a_d} + {1'b0, b_eff} + {4'b0, dcarry[g]};
    assign fix   = raw[4] | (raw[3] & (raw[2] | raw[1]));
    assign out_d = raw[3:0] + (fix ? 4'd6 : 4'd0);

    assign result[4*g +: 4] = out_d;
    assign dcarry[g+1]      = fix;

    always_comb begin
      if (a_d <= 4'd9 && b_d <= 4'd9) begin
        AST_DIGIT_LEGAL: assert (out_d <= 4'd9) else $error("place %0d digit %0d", g, out_d); // R3
        AST_DIGIT_BALANCE: assert (({1'b0, out_d} + (dcarry[g+1] ? 5'd10 : 5'd0)) == ({1'b0, a_d} + {1'b0, b_eff} + {4'b0, dcarry[g]})) else $error("place %0d unbalanced", g); // R9
        if (sub_mode) begin
          AST_NINES: assert (({1'b0, b_eff} + {1'b0, b_d}) == 5'd9) else $error("place %0d complement", g); // R6
        end
        if (({1'b0, a_d} + {1'b0, b_eff} + {4'b0, dcarry[g]}) <= 5'd9) begin
          AST_NO_FIX_SMALL: assert (!dcarry[g+1] && out_d == raw[3:0]) else $error("place %0d corrected", g); // R2
        end
      end
    end
  end

endmodule

// File: tb/bcd_addsub_tb.sv
`timescale 1ns/1ps
module bcd_addsub_tb;
  localparam int DIGITS = 3;
  localparam int W = 4 * DIGITS;
  localparam int MOD = 10 ** DIGITS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] opa = '0, opb = '0, result;
  logic sub_mode = 1'b0, cin = 1'b0, cout;
  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bcd_addsub #(.DIGITS(DIGITS)) u_dut (
    .opa(opa), .opb(opb), .sub_mode(sub_mode), .cin(cin),
    .result(result), .cout(cout)
  );

  function automatic logic [W-1:0] to_bcd(input int v);
    logic [W-1:0] r = '0;
    int x = v;
    for (int i = 0; i < DIGITS; i++) begin
      r[4*i +: 4] = 4'(x % 10);
      x = x / 10;
    end
    return r;
  endfunction

  task automatic run(input int a, input int b, input logic s, input logic c, input string tag);
    int total;
    logic [W-1:0] exp_r;
    logic exp_c;
    @(posedge clk);
    #1;
    opa = to_bcd(a); opb = to_bcd(b); sub_mode = s; cin = c;
    @(negedge clk);
    total = s ? (a + (MOD - 1 - b) + int'(c)) : (a + b + int'(c));
    exp_c = (total >= MOD);
    exp_r = to_bcd(total % MOD);
    n_tests++;
    if (result !== exp_r || cout !== exp_c) begin
      n_fail++;
      $display("FAIL %s: a=%0d b=%0d sub=%b cin=%b got %h/%b expected %h/%b",
               tag, a, b, s, c, result, cout, exp_r, exp_c);
    end
  endtask

  initial begin
    repeat (2) @(posedge clk);
    rst = 1'b0;
    run(0, 0, 1'b0, 1'b0, "R1");
    run(123, 456, 1'b0, 1'b0, "R1");
    run(34, 43, 1'b0, 1'b0, "R2");
    run(999, 999, 1'b0, 1'b1, "R4");
    run(999, 1, 1'b0, 1'b0, "R5");
    run(999, 0, 1'b0, 1'b1, "R5");
    run(500, 499, 1'b0, 1'b1, "R9");
    run(500, 499, 1'b0, 1'b0, "R9");
    run(750, 250, 1'b1, 1'b1, "R7");
    run(250, 750, 1'b1, 1'b1, "R8");
    run(321, 321, 1'b1, 1'b1, "R7");
    run(0, 1, 1'b1, 1'b1, "R8");
    run(400, 123, 1'b1, 1'b0, "R10");
    for (int d = 0; d < 10; d++)
      for (int e = 0; e < 10; e++)
        for (int m = 0; m < 2; m++)
          for (int c = 0; c < 2; c++) begin
            int a = d * 111;
            int b = e * 111;
            string tag;
            if (m == 1) tag = (c == 1) ? ((a >= b) ? "R7" : "R8") : "R10";
            else        tag = (d + e + c > 9) ? "R3" : "R2";
            run(a, b, 1'(m), 1'(c), tag);
          end
    for (int k = 0; k < 1500; k++) begin
      int a = int'($urandom % MOD);
      int b = int'($urandom % MOD);
      logic s = 1'($urandom);
      run(a, b, s, s ? 1'b1 : 1'($urandom), s ? "R6" : "R1");
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule